// File: doc/BRIEF.md
# Condition-Tested Predicated Vector Writeback

This block steps through a vector of up to `MAXVL` elements, one element per clock. For each element it adds or subtracts two integer operands and sorts the result into three condition flags: less-than, greater-than and equal. A per-element predicate mask decides whether the element takes part at all. For an element that does take part, a test on one of its own new flags decides whether the result reaches the destination register file. The flags can be stored to the condition-field file even when that test fails, so software can later see which elements were rejected.

A single `start` pulse latches the vector length, the operands, the predicate mask, the destination base index, the condition-field offset and the mode bits. The block then sends out at most one condition-field write and one destination write per cycle. A compare-only form stores only the flags. A zeroing form writes zero in place of every element that is masked out or rejected.

Top module: `crtest_wb`

## Requirements
- R1: An element whose latched predicate bit is 0 makes no condition-field write and no result write. It is written as zero only when zeroing is on (R7).
- R2: For an active element the result is `a+b` when `op_sub`=0 and `a-b` when `op_sub`=1, taken modulo 2^XLEN. `cr_flags` is {lt,gt,eq}, with lt at bit 2, gt at bit 1 and eq at bit 0. The result is compared as signed against zero, so exactly one flag is set.
- R3: When `rc`=1 or `rc1`=1, every active element i writes its flags at `cr_idx` = `cr_offs`+i (modulo 2^CIDX). This happens whether or not the test passes.
- R4: `flag_sel` picks the tested flag: 0 = lt, 1 = gt, 2 = eq, 3 = a constant-zero flag. The test passes when the picked flag equals `flag_want`.
- R5: An active element that passes the test, with `rc1`=0, writes its result at `rd_idx` = `rt_base`+i (modulo 2^RIDX). An element that fails writes nothing, unless zeroing is on.
- R6: With `rc1`=1, no element ever writes its result. Condition fields are still stored for the active elements.
- R7: With `zero_en`=1, every element that is masked out, fails the test, or runs in compare-only form writes zero at `rt_base`+i.
- R8: With `rc`=0 and `rc1`=0, no condition field is written.
- R9: After reset the block is idle, with `done` low and no writes. Element i is presented i+1 cycles after the start edge. `done` pulses for one cycle, one cycle after the last element. A length of 0 gives `done` in the cycle after `start`, with no writes.
- R10: A `start` pulse while `busy` is high is ignored, and so are changes on the other inputs while `busy` is high.
- R11: A requested length above `MAXVL` is processed as `MAXVL` elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch the job and begin |
| vl | input | VLW | Requested element count |
| rt_base | input | RIDX | Destination base register index |
| cr_offs | input | CIDX | Condition-field base index |
| op_sub | input | 1 | 0 add, 1 subtract |
| rc | input | 1 | Store condition fields |
| rc1 | input | 1 | Compare-only form |
| flag_sel | input | 2 | Tested flag selector |
| flag_want | input | 1 | Value the tested flag must hold |
| zero_en | input | 1 | Zeroing form |
| pred | input | MAXVL | Predicate mask, bit i for element i |
| op_a | input | MAXVL*XLEN | First operands, element i at bits i*XLEN |
| op_b | input | MAXVL*XLEN | Second operands |
| busy | output | 1 | Elements in progress |
| done | output | 1 | One-cycle completion pulse |
| cr_we | output | 1 | Condition-field write enable |
| cr_idx | output | CIDX | Condition-field write index |
| cr_flags | output | 3 | {lt,gt,eq} |
| rd_we | output | 1 | Destination write enable |
| rd_idx | output | RIDX | Destination write index |
| rd_data | output | XLEN | Destination write data |

## Verification
On every cycle the assertions check the following: writes occur only while busy, each stored field carries one flag, a nonzero written result agrees in sign with its flags, the indices advance together, the latched length holds, and `done` follows a busy run or a start. Only the bench scenarios can show whether the right elements are skipped, rejected, zeroed or written with the right values. They also cover the selector and the wanted value, compare-only mode, the length clamp, and the ignoring of a start pulse that arrives mid-run.

// File: rtl/crtest_wb.sv
module crtest_wb #(
  parameter int XLEN  = 16,
  parameter int MAXVL = 8,
  parameter int RIDX  = 6,
  parameter int CIDX  = 6,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [VLW-1:0]        vl,
  input  logic [RIDX-1:0]       rt_base,
  input  logic [CIDX-1:0]       cr_offs,
  input  logic                  op_sub,
  input  logic                  rc,
  input  logic                  rc1,
  input  logic [1:0]            flag_sel,
  input  logic                  flag_want,
  input  logic                  zero_en,
  input  logic [MAXVL-1:0]      pred,
  input  logic [MAXVL*XLEN-1:0] op_a,
  input  logic [MAXVL*XLEN-1:0] op_b,
  output logic                  busy,
  output logic                  done,
  output logic                  cr_we,
  output logic [CIDX-1:0]       cr_idx,
  output logic [2:0]            cr_flags,
  output logic                  rd_we,
  output logic [RIDX-1:0]       rd_idx,
  output logic [XLEN-1:0]       rd_data
);
  logic                  busy_q, done_q;
  logic [VLW-1:0]        vl_q, idx_q;
  logic [RIDX-1:0]       rt_q;
  logic [CIDX-1:0]       offs_q;
  logic                  sub_q, rc_q, rc1_q, want_q, zen_q;
  logic [1:0]            sel_q;
  logic [MAXVL-1:0]      pred_q;
  logic [MAXVL*XLEN-1:0] a_q, b_q;

  wire [VLW-1:0] vl_cl = (vl > VLW'(MAXVL)) ? VLW'(MAXVL) : vl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      vl_q   <= '0;
      idx_q  <= '0;
      rt_q   <= '0;
      offs_q <= '0;
      sub_q  <= 1'b0;
      rc_q   <= 1'b0;
      rc1_q  <= 1'b0;
      want_q <= 1'b0;
      zen_q  <= 1'b0;
      sel_q  <= '0;
      pred_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        vl_q   <= vl_cl;
        idx_q  <= '0;
        rt_q   <= rt_base;
        offs_q <= cr_offs;
        sub_q  <= op_sub;
        rc_q   <= rc;
        rc1_q  <= rc1;
        want_q <= flag_want;
        zen_q  <= zero_en;
        sel_q  <= flag_sel;
        pred_q <= pred;
        a_q    <= op_a;
        b_q    <= op_b;
        if (vl_cl == '0) done_q <= 1'b1;
        else             busy_q <= 1'b1;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == vl_q - 1'b1) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  wire [XLEN-1:0] ea  = a_q[int'(idx_q)*XLEN +: XLEN];
  wire [XLEN-1:0] eb  = b_q[int'(idx_q)*XLEN +: XLEN];
  wire [XLEN-1:0] res = sub_q ? ea - eb : ea + eb;

  wire lt = res[XLEN-1];
  wire eq = (res == '0);
  wire gt = !lt && !eq;
  wire [3:0] fl4 = {1'b0, eq, gt, lt};
  wire pass = (fl4[sel_q] == want_q);

  wire act  = busy_q && |(pred_q & (MAXVL'(1) << idx_q));
  wire keep = act && pass && !rc1_q;

  assign busy     = busy_q;
  assign done     = done_q;
  assign cr_we    = act && (rc_q || rc1_q);
  assign cr_idx   = offs_q + CIDX'(idx_q);
  assign cr_flags = {lt, gt, eq};
  assign rd_we    = keep || (busy_q && zen_q);
  assign rd_idx   = rt_q + RIDX'(idx_q);
  assign rd_data  = keep ? res : '0;
endmodule

// File: rtl/crtest_wb_chk.sv
module crtest_wb_chk #(
  parameter int XLEN = 16,
  parameter int RIDX = 6,
  parameter int CIDX = 6,
  parameter int VLW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            cr_we,
  input logic [CIDX-1:0] cr_idx,
  input logic [2:0]      cr_flags,
  input logic            rd_we,
  input logic [RIDX-1:0] rd_idx,
  input logic [XLEN-1:0] rd_data,
  input logic [VLW-1:0]  vl_q
);
  a_r9_writes_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we || rd_we) |-> busy);

  a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> ($countones(cr_flags) == 1));

  a_r2_sign_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && rd_we && rd_data != '0) |-> (cr_flags[2] == rd_data[XLEN-1] && !cr_flags[0]));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(start)));

  a_r10_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(vl_q));

  a_r5_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (rd_idx - $past(rd_idx) == RIDX'(1)));

  a_r3_cr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cr_idx - $past(cr_idx) == CIDX'(1)));
endmodule

bind crtest_wb crtest_wb_chk #(.XLEN(XLEN), .RIDX(RIDX), .CIDX(CIDX), .VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cr_we(cr_we), .cr_idx(cr_idx), .cr_flags(cr_flags), .rd_we(rd_we),
  .rd_idx(rd_idx), .rd_data(rd_data), .vl_q(vl_q)
);

// File: tb/tb_crtest_wb.sv
`timescale 1ns/1ps
module tb_crtest_wb;
  localparam int XLEN = 16, MAXVL = 8, RIDX = 6, CIDX = 6, VLW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [VLW-1:0] vl = '0;
  logic [RIDX-1:0] rt_base = '0;
  logic [CIDX-1:0] cr_offs = '0;
  logic op_sub = 0, rc = 0, rc1 = 0, flag_want = 0, zero_en = 0;
  logic [1:0] flag_sel = '0;
  logic [MAXVL-1:0] pred = '0;
  logic [MAXVL*XLEN-1:0] op_a = '0, op_b = '0;
  logic busy, done, cr_we, rd_we;
  logic [CIDX-1:0] cr_idx;
  logic [2:0] cr_flags;
  logic [RIDX-1:0] rd_idx;
  logic [XLEN-1:0] rd_data;

  int tests = 0, fails = 0;
  logic [XLEN-1:0] ta [MAXVL];
  logic [XLEN-1:0] tb [MAXVL];

  always #2 clk = ~clk;

  crtest_wb #(.XLEN(XLEN), .MAXVL(MAXVL), .RIDX(RIDX), .CIDX(CIDX)) dut (.*);

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_case(string req, int vin, bit sub, bit rcb, bit rc1b, logic [1:0] s,
                          bit w, bit z, logic [MAXVL-1:0] p, bit poke);
    int n = (vin > MAXVL) ? MAXVL : vin;
    for (int i = 0; i < MAXVL; i++) begin
      op_a[i*XLEN +: XLEN] = ta[i];
      op_b[i*XLEN +: XLEN] = tb[i];
    end
    @(negedge clk);
    vl = VLW'(vin); rt_base = 6'd10; cr_offs = 6'd60; op_sub = sub; rc = rcb; rc1 = rc1b;
    flag_sel = s; flag_want = w; zero_en = z; pred = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [XLEN-1:0] r;
      logic lt, eq, gt, pass, act, keep, ecw, erw;
      logic [3:0] f4;
      r = sub ? ta[k] - tb[k] : ta[k] + tb[k];
      lt = r[XLEN-1]; eq = (r == 0); gt = !lt && !eq;
      f4 = {1'b0, eq, gt, lt};
      pass = (f4[s] == w);
      act = p[k];
      keep = act && pass && !rc1b;
      ecw = act && (rcb || rc1b);
      erw = keep || z;
      check(req,
            {31'd0, cr_we, cr_we ? cr_idx : 6'd0, cr_we ? cr_flags : 3'd0,
             rd_we, rd_we ? rd_idx : 6'd0, rd_we ? rd_data : 16'd0},
            {31'd0, ecw, ecw ? 6'(60 + k) : 6'd0, ecw ? {lt, gt, eq} : 3'd0,
             erw, erw ? 6'(10 + k) : 6'd0, keep ? r : 16'd0});
      if (poke && k == 1) begin
        start = 1'b1; vl = 4'd1; rt_base = 6'd3; pred = '0; rc = ~rcb; zero_en = ~z;
        op_a = '1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check({req, " R9 done"}, {62'd0, done, busy | cr_we | rd_we}, {62'd0, 1'b1, 1'b0});
    @(negedge clk);
    check({req, " R9 pulse"}, {63'd0, done | busy | cr_we | rd_we}, 64'd0);
  endtask

  task automatic t_reset();
    check("R9 reset", {60'd0, busy, done, cr_we, rd_we}, 64'd0);
  endtask

  task automatic t_basic();
    ta = '{16'd5, 16'd3, 16'd1, 16'hFFF0, 16'd0, 16'd7, 16'h8000, 16'd2};
    tb = '{16'd2, 16'hFFFD, 16'hFFF0, 16'd4, 16'd0, 16'd9, 16'd0, 16'hFFFE};
    run_case("R2 R3 R5", 8, 0, 1, 0, 2'd2, 0, 0, 8'hFF, 0);
  endtask

  task automatic t_mask_sub();
    ta = '{16'd9, 16'd3, 16'd4, 16'd1, 16'd6, 16'd0, 16'd8, 16'd2};
    tb = '{16'd9, 16'd5, 16'd1, 16'd1, 16'd2, 16'd3, 16'd8, 16'd1};
    run_case("R1 R2 R4", 8, 1, 1, 0, 2'd3, 0, 0, 8'b10110101, 0);
  endtask

  task automatic t_sel();
    ta = '{16'd9, 16'd3, 16'd4, 16'd1, 16'd6, 16'd0, 16'd8, 16'd2};
    tb = '{16'd9, 16'd5, 16'd1, 16'd1, 16'd2, 16'd3, 16'd8, 16'd1};
    run_case("R4 R5 lt", 8, 1, 1, 0, 2'd0, 1, 0, 8'hFF, 0);
    run_case("R4 R5 gt", 8, 1, 1, 0, 2'd1, 0, 0, 8'hFF, 0);
    run_case("R4 never", 6, 1, 1, 0, 2'd3, 1, 0, 8'hFF, 0);
  endtask

  task automatic t_rc0();
    run_case("R8", 8, 0, 0, 0, 2'd2, 0, 0, 8'b11011011, 0);
  endtask

  task automatic t_rc1();
    run_case("R6", 8, 1, 0, 1, 2'd2, 0, 0, 8'b01111110, 0);
  endtask

  task automatic t_zero();
    run_case("R7", 8, 1, 1, 0, 2'd2, 0, 1, 8'b10101110, 0);
    run_case("R6 R7", 5, 1, 0, 1, 2'd3, 0, 1, 8'b00010110, 0);
  endtask

  task automatic t_len();
    run_case("R9 len0", 0, 0, 1, 0, 2'd3, 0, 1, 8'hFF, 0);
    run_case("R9 len1", 1, 0, 1, 0, 2'd3, 0, 0, 8'hFF, 0);
    run_case("R11", 12, 1, 1, 0, 2'd1, 1, 0, 8'hFF, 0);
  endtask

  task automatic t_busy_start();
    ta = '{16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8};
    tb = '{16'd1, 16'd1, 16'd1, 16'd9, 16'd1, 16'd1, 16'd1, 16'd1};
    run_case("R10", 6, 1, 1, 0, 2'd1, 1, 0, 8'b00111111, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask_sub();
    t_sel();
    t_rc0();
    t_rc1();
    t_zero();
    t_len();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule